// File: doc/BRIEF.md
# Fine-Resolution Pulse-Width Modulator

This block produces a single PWM output with 14 bits of average resolution from an 8-bit coarse value M and a 6-bit fine value N. Each base cycle is 256 clocks long, and the output is high for the first M clocks of it. Over a frame of 64 base cycles, N selects cycles that are lengthened by one extra high clock. The chosen cycles are spread as evenly as the binary weights of N allow, so the long-run duty comes to (M + N/64)/256.

Software writes M and N through a one-cycle write strobe into holding registers. The running generator adopts them only when one frame ends and the next begins, so a frame always follows one consistent pair of values. Pulling the enable low stops the generator and forces the output low. When the enable rises again, the generator starts a new frame.

Top module: `brm_pwm`

## Requirements
- R1: While the synchronous reset is high, the output is low. After reset, the coarse and fine values in use are both 0 and both counters are at 0.
- R2: With the enable high, each base cycle lasts 256 clocks. In a cycle that is not stretched, the output is high for exactly the first M clocks, at offsets 0 to M-1, and low for the rest.
- R3: M=0 with N=0 gives a constant low output. M=255 with N=0 gives 255 high clocks in every 256.
- R4: A stretched cycle is high for M+1 clocks. The extra high clock sits at offset M, immediately after the normal high clocks. With M=255 a stretched cycle is high for all 256 clocks.
- R5: Number the cycles in a frame k = 0..63. Cycle k is stretched when k is odd and N[5] is set, or k mod 4 = 2 and N[4] is set, or k mod 8 = 4 and N[3] is set, or k mod 16 = 8 and N[2] is set, or k mod 32 = 16 and N[1] is set, or k = 32 and N[0] is set. Cycle 0 is never stretched.
- R6: Over one whole frame of 64 cycles, the number of high clocks is 64*M + N.
- R7: With M and N unchanged, the output pattern repeats every 64 base cycles (16384 clocks).
- R8: A write (write strobe high for one clock, coarse and fine data sampled together) changes nothing in the frame that is running. The new values take effect from cycle 0 of the next frame.
- R9: While the enable is low, the output is low and both counters are held at 0, and values written in this state are adopted directly. The first clock with the enable high is offset 0 of frame cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Runs the generator when high |
| wr_en | input | 1 | Write strobe for the coarse and fine values |
| wr_coarse | input | 8 | Coarse duty value M |
| wr_fine | input | 6 | Fine duty value N |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a write that lands in the middle of a running frame. The old values must then hold through the remaining cycles, and the new ones must start exactly at cycle 0 of the next frame. The stimulus enables the block, writes a second pair of values ten cycles into the frame, and compares every base cycle of two frames against the expected high-clock counts. The value pairs are chosen so the two frames differ in both M and the stretch pattern. A second awkward case is a restart after the enable drops mid-frame. There a fine value with only its lowest bit set makes a single stretched cycle, and that cycle shows up in the wrong place if the frame counter is not cleared.

// File: rtl/brm_pwm.sv
module brm_pwm #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_coarse,
  input  logic [FW-1:0] wr_fine,
  output logic          pwm_out
);
  localparam logic [CW-1:0] CNT_LAST = '1;
  localparam logic [FW-1:0] FRM_LAST = '1;

  logic [CW-1:0] cnt, coarse_q, coarse_nx;
  logic [FW-1:0] frm, fine_q, fine_nx;
  logic          cyc_end, frame_end, stretch, found;

  assign cyc_end   = (cnt == CNT_LAST);
  assign frame_end = en && cyc_end && (frm == FRM_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      frm       <= '0;
      coarse_q  <= '0;
      fine_q    <= '0;
      coarse_nx <= '0;
      fine_nx   <= '0;
    end else begin
      if (wr_en) begin
        coarse_nx <= wr_coarse;
        fine_nx   <= wr_fine;
      end
      if (!en) begin
        cnt      <= '0;
        frm      <= '0;
        coarse_q <= coarse_nx;
        fine_q   <= fine_nx;
      end else begin
        cnt <= cnt + 1'b1;
        if (cyc_end) frm <= frm + 1'b1;
        if (frame_end) begin
          coarse_q <= coarse_nx;
          fine_q   <= fine_nx;
        end
      end
    end
  end

  always_comb begin
    stretch = 1'b0;
    found   = 1'b0;
    for (int t = 0; t < FW; t++) begin
      if (!found && frm[t]) begin
        stretch = fine_q[FW-1-t];
        found   = 1'b1;
      end
    end
  end

  assign pwm_out = en && ((cnt < coarse_q) || (stretch && (cnt == coarse_q)));
endmodule

// File: rtl/brm_pwm_chk.sv
module brm_pwm_chk #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          pwm_out,
  input logic [CW-1:0] cnt,
  input logic [FW-1:0] frm,
  input logic [CW-1:0] coarse_q,
  input logic [FW-1:0] fine_q
);
  localparam logic [CW-1:0] CNT_LAST = '1;
  localparam logic [FW-1:0] FRM_LAST = '1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && frm == '0 && coarse_q == '0 && fine_q == '0 && !pwm_out));

  p_prefix_high_r2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt < coarse_q) |-> pwm_out);

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == CNT_LAST) |=> (cnt == '0));

  p_frame0_plain_r5: assert property (@(posedge clk) disable iff (rst)
    (en && frm == '0 && cnt >= coarse_q) |-> !pwm_out);

  p_frame_step_r7: assert property (@(posedge clk) disable iff (rst)
    (en && cnt == CNT_LAST) |=> (frm == $past(frm) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !(cnt == CNT_LAST && frm == FRM_LAST)) |=> ($stable(coarse_q) && $stable(fine_q)));

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0 && frm == '0));
endmodule

bind brm_pwm brm_pwm_chk #(.CW(CW), .FW(FW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pwm_out(pwm_out),
  .cnt(cnt), .frm(frm), .coarse_q(coarse_q), .fine_q(fine_q)
);

// File: tb/tb_brm_pwm.sv
module tb_brm_pwm;
  logic clk = 1'b0, rst = 1'b1, en = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_coarse = '0;
  logic [5:0] wr_fine = '0;
  logic pwm_out;

  brm_pwm dut (.clk(clk), .rst(rst), .en(en), .wr_en(wr_en),
               .wr_coarse(wr_coarse), .wr_fine(wr_fine), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  typedef struct { int hi; string tag; } item_t;
  item_t cyc_q[$];
  item_t tot_q[$];
  int n_chk = 0, n_err = 0;
  bit mon_on = 1'b0, done = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit stretched(int k, logic [5:0] n);
    return (k % 2 == 1 && n[5]) || (k % 4 == 2 && n[4]) || (k % 8 == 4 && n[3]) ||
           (k % 16 == 8 && n[2]) || (k % 32 == 16 && n[1]) || (k == 32 && n[0]);
  endfunction

  // driver side: expected high-clock count of each base cycle, and of each whole frame
  task automatic push_cycles(int m, logic [5:0] n, int ncyc, string tag);
    int tot = 0;
    for (int k = 0; k < ncyc; k++) begin
      item_t it;
      it.hi = m + int'(stretched(k % 64, n));
      it.tag = (it.hi != m) ? {tag, "/R4"} : tag;
      tot += it.hi;
      cyc_q.push_back(it);
      if (k % 64 == 63) begin
        item_t ft;
        ft.hi = 64 * m + int'(n);
        ft.tag = {tag, "/R6"};
        chk(tot == ft.hi, "R6 model", tot, ft.hi);
        tot_q.push_back(ft);
        tot = 0;
      end
    end
  endtask

  task automatic write_vals(int m, int n);
    @(negedge clk);
    wr_en = 1'b1; wr_coarse = 8'(m); wr_fine = 6'(n);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(int ncyc);
    @(negedge clk);
    en = 1'b1; mon_on = 1'b1;
    repeat (ncyc * 256) @(negedge clk);
    en = 1'b0; mon_on = 1'b0;
    @(negedge clk);
    chk(cyc_q.size() == 0 && tot_q.size() == 0, "R2 queue drained", cyc_q.size(), 0);
  endtask

  // monitor: samples after the driver at each falling edge
  int pos = 0, hi_cyc = 0, hi_frm = 0, fcyc = 0;
  bit shape_bad = 1'b0;
  item_t cur;
  always @(negedge clk) begin
    #1;
    if (!mon_on) begin
      pos = 0; hi_cyc = 0; hi_frm = 0; fcyc = 0; shape_bad = 1'b0;
    end else begin
      if (pos == 0) begin
        if (cyc_q.size() == 0) begin
          cur.hi = -1; cur.tag = "R2 unexpected cycle";
        end else cur = cyc_q.pop_front();
      end
      if (pwm_out !== (pos < cur.hi)) shape_bad = 1'b1;
      if (pwm_out === 1'b1) hi_cyc++;
      pos++;
      if (pos == 256) begin
        chk(hi_cyc == cur.hi && !shape_bad, cur.tag, hi_cyc, cur.hi);
        hi_frm += hi_cyc;
        pos = 0; hi_cyc = 0; shape_bad = 1'b0;
        fcyc++;
        if (fcyc == 64) begin
          item_t ft;
          if (tot_q.size() == 0) begin ft.hi = -1; ft.tag = "R6 unexpected"; end
          else ft = tot_q.pop_front();
          chk(hi_frm == ft.hi, ft.tag, hi_frm, ft.hi);
          fcyc = 0; hi_frm = 0;
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int m, n;
    repeat (3) @(negedge clk);
    chk(pwm_out === 1'b0, "R1 low in reset", pwm_out, 0);
    rst = 1'b0; en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    #1 chk(pwm_out === 1'b0, "R1 zero values after reset", pwm_out, 0);
    @(negedge clk);
    en = 1'b0;

    // R3 extremes
    write_vals(0, 0);
    push_cycles(0, 6'd0, 4, "R3 M=0");
    run(4);
    write_vals(255, 0);
    push_cycles(255, 6'd0, 4, "R3 M=255");
    run(4);

    // R9: disabled output stays low with M=255 in use
    begin
      int highs = 0;
      repeat (20) begin @(negedge clk); #1 if (pwm_out !== 1'b0) highs++; end
      chk(highs == 0, "R9 low while disabled", highs, 0);
    end

    // R9: stop mid-frame, restart must begin at frame cycle 0
    write_vals(8'h40, 6'h01);
    push_cycles(8'h40, 6'h01, 20, "R9 partial");
    run(20);
    push_cycles(8'h40, 6'h01, 64, "R9 restart");
    run(64);

    // R4 full-high stretched cycles
    write_vals(255, 63);
    push_cycles(255, 6'h3F, 64, "R4 M=255 N=63");
    run(64);

    // R5/R6 random values, R7 two consecutive frames
    for (int i = 0; i < 2; i++) begin
      m = int'($urandom_range(1, 254)); n = int'($urandom_range(0, 63));
      write_vals(m, n);
      push_cycles(m, 6'(n), 64, "R5 random");
      run(64);
    end
    m = int'($urandom_range(1, 254)); n = int'($urandom_range(1, 62));
    write_vals(m, n);
    push_cycles(m, 6'(n), 128, "R7 repeat");
    run(128);

    // R8 write during a running frame
    write_vals(8'h21, 6'h15);
    push_cycles(8'h21, 6'h15, 64, "R8 old frame");
    push_cycles(8'hC3, 6'h2A, 64, "R8 new frame");
    @(negedge clk);
    en = 1'b1; mon_on = 1'b1;
    repeat (10 * 256) @(negedge clk);
    wr_en = 1'b1; wr_coarse = 8'hC3; wr_fine = 6'h2A;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (128 * 256 - 10 * 256 - 1) @(negedge clk);
    en = 1'b0; mon_on = 1'b0;
    @(negedge clk);
    chk(cyc_q.size() == 0 && tot_q.size() == 0, "R8 queue drained", cyc_q.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule